// File: doc/BRIEF.md
# Single-Byte-Addressed Two-Wire Memory Slave

This block is the bus-facing side of a 128-byte serial memory that sits on a two-wire open-drain bus. The master opens each transfer with a START condition. It then sends one byte whose upper seven bits select a memory location and whose lowest bit chooses the direction. There is no separate device-select stage. The block samples the two bus lines into the system clock and finds START, STOP and SCL edges. It acknowledges bytes by pulling SDA low through an output enable. In a read it shifts data out from the byte array it holds. In a write it presents each accepted byte, together with its target address, to a page-buffer block outside this one.

A STOP that ends a write hands the buffered page to the programming controller through a one-cycle commit pulse. While that controller reports a programming cycle through the busy input, the block stays silent on the bus. The controller also owns the array's write port. It loads the programmed bytes into the array here, so that later reads return them. A write-control input, when high at any moment from START to the end of the address byte, turns a write into a no-op whose data bytes go unacknowledged.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset the SDA output enable is low, no write strobe or commit pulse is given, and every array byte reads as 8'hFF.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. The first byte after START is taken MSB first, with bits 7..1 as the byte address and bit 0 as direction (1 = read, 0 = write). The block pulls SDA low during the 9th clock to acknowledge it.
- R3: In a read the addressed byte is driven MSB first, one bit per SCL low phase. The level on SDA is valid while SCL is high.
- R4: When the master acknowledges a read byte (SDA low on the 9th clock), the byte at address+1 follows. Address 127 is followed by address 0.
- R5: When the master leaves SDA high on the 9th clock of a read, the block releases SDA and drives nothing more until the next START.
- R6: In a write, each data byte is acknowledged and appears for one cycle on the write strobe with its address and value.
- R7: Within a write the address advances only in its two low bits (0..3 wrap). Bits 6..2 stay as received, so a fifth byte lands on the first byte's address.
- R8: A STOP after a write with at least one accepted data byte gives exactly one commit pulse. A STOP after a read, or after a write with no data byte, gives none.
- R9: If write-control is high in any cycle from START through the end of the address byte, the address is still acknowledged. The data bytes are not acknowledged, no write strobe or commit is given, and the memory content stays unchanged.
- R10: Write-control changes after the address byte has been acknowledged have no effect on data acknowledges, strobes or commit.
- R11: While busy is high, the block acknowledges nothing, including the address byte, and gives no strobe or commit.
- R12: The SDA output enable changes only in the clock cycle right after a detected SCL falling edge, so the block never creates a START or STOP itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired, including this block's own pull-down) |
| sda_oe_o | output | 1 | High pulls SDA low |
| wc_i | input | 1 | Write-control; high blocks writes |
| busy_i | input | 1 | Programming cycle in progress |
| wr_stb_o | output | 1 | One-cycle strobe per accepted write byte |
| wr_addr_o | output | ADDR_W | Address of the strobed byte |
| wr_data_o | output | DATA_W | Value of the strobed byte |
| commit_o | output | 1 | One-cycle pulse: start programming the buffered page |
| pgm_we_i | input | 1 | Array write enable from the programming controller |
| pgm_addr_i | input | ADDR_W | Array write address |
| pgm_data_i | input | DATA_W | Array write data |

## Verification
The hardest situations to reach from the ports are those where a timing window on a side input decides the outcome. One is write-control going high only in the START cycle and dropping before the address bits arrive. Another is a new START landing while the programming controller is still busy. The bench's master model holds write-control high across just the START sequence, then lowers it before the first address bit. It also opens a transfer at once after a committing STOP, so that the address byte falls inside the busy window. These directed cases are mixed with seeded random reads and writes, with random lengths, addresses and write-control. The random writes cross page boundaries, and the random reads cross the 127-to-0 wrap.

// File: rtl/tw_mem_pkg.sv
package tw_mem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } tw_state_e;

  // Next write address: only the low page_bits bits count, the rest is kept.
  function automatic int unsigned page_next(int unsigned a, int unsigned page_bits);
    int unsigned mask;
    mask = (32'd1 << page_bits) - 32'd1;
    return (a & ~mask) | ((a + 32'd1) & mask);
  endfunction

  // Next read address: full counter wrapping at 2**addr_bits.
  function automatic int unsigned wrap_next(int unsigned a, int unsigned addr_bits);
    return (a + 32'd1) & ((32'd1 << addr_bits) - 32'd1);
  endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic q_prev_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], d_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign q_o      = chain[STAGES-1];
  assign q_prev_o = prev;
endmodule

// File: rtl/tw_byte_store.sv
module tw_byte_store #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cells[g] <= '1;
      else if (we_i && (waddr_i == ADDR_W'(g)))
        cells[g] <= wdata_i;
    end
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
  import tw_mem_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 2,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              wc_i,
  input  logic              busy_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              commit_o,
  input  logic              pgm_we_i,
  input  logic [ADDR_W-1:0] pgm_addr_i,
  input  logic [DATA_W-1:0] pgm_data_i
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  // synchronised bus lines
  logic scl_s, scl_p, sda_s, sda_p;

  tw_line_sync #(.STAGES(SYNC_STG)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s), .q_prev_o(scl_p));
  tw_line_sync #(.STAGES(SYNC_STG)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s), .q_prev_o(sda_p));

  // named bus events
  logic scl_rise_w, scl_fall_w, start_w, stop_w;
  assign scl_rise_w = scl_s & ~scl_p;
  assign scl_fall_w = ~scl_s & scl_p;
  assign start_w    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_w     = scl_s & scl_p & ~sda_p & sda_s;

  tw_state_e         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic [ADDR_W-1:0] cur_addr;
  logic              rw_read;
  logic              wc_block;
  logic              mst_ack;
  logic              got_data;

  logic [ADDR_W-1:0] rd_next_w, wr_next_w, rd_sel_w;
  logic [DATA_W-1:0] rd_data_w;

  assign rd_next_w = ADDR_W'(wrap_next(32'(cur_addr), ADDR_W));
  assign wr_next_w = ADDR_W'(page_next(32'(cur_addr), PAGE_BITS));
  assign rd_sel_w  = (state == ST_RACK) ? rd_next_w : cur_addr;

  tw_byte_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we_i(pgm_we_i), .waddr_i(pgm_addr_i), .wdata_i(pgm_data_i),
    .raddr_i(rd_sel_w), .rdata_o(rd_data_w));

  logic in_write_w;
  assign in_write_w = (state == ST_WDATA) || (state == ST_WACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      cur_addr  <= '0;
      rw_read   <= 1'b0;
      wc_block  <= 1'b0;
      mst_ack   <= 1'b0;
      got_data  <= 1'b0;
      sda_oe_o  <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      commit_o  <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      commit_o <= 1'b0;
      if (busy_i) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
        got_data <= 1'b0;
      end else if (stop_w) begin
        if (in_write_w && got_data && !wc_block)
          commit_o <= 1'b1;
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
        got_data <= 1'b0;
      end else if (start_w) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        wc_block <= wc_i;
        sda_oe_o <= 1'b0;
        got_data <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            wc_block <= wc_block | wc_i;
            if (scl_rise_w) begin
              shreg   <= {shreg[DATA_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall_w && bit_cnt == CNT_FULL) begin
              cur_addr <= shreg[DATA_W-1 -: ADDR_W];
              rw_read  <= shreg[0];
              sda_oe_o <= 1'b1;
              state    <= ST_ADDR_ACK;
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_w) begin
              bit_cnt <= '0;
              if (rw_read) begin
                shreg    <= rd_data_w;
                sda_oe_o <= ~rd_data_w[DATA_W-1];
                state    <= ST_RDATA;
              end else begin
                sda_oe_o <= 1'b0;
                state    <= ST_WDATA;
              end
            end
          end
          ST_WDATA: begin
            if (scl_rise_w) begin
              shreg   <= {shreg[DATA_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall_w && bit_cnt == CNT_FULL) begin
              if (!wc_block) begin
                sda_oe_o  <= 1'b1;
                wr_stb_o  <= 1'b1;
                wr_addr_o <= cur_addr;
                wr_data_o <= shreg;
                cur_addr  <= wr_next_w;
                got_data  <= 1'b1;
              end
              state <= ST_WACK;
            end
          end
          ST_WACK: begin
            if (scl_fall_w) begin
              sda_oe_o <= 1'b0;
              bit_cnt  <= '0;
              state    <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall_w) begin
              if (bit_cnt == CNT_LAST) begin
                sda_oe_o <= 1'b0;
                bit_cnt  <= '0;
                state    <= ST_RACK;
              end else begin
                shreg    <= {shreg[DATA_W-2:0], 1'b0};
                sda_oe_o <= ~shreg[DATA_W-2];
                bit_cnt  <= bit_cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_w)
              mst_ack <= ~sda_s;
            else if (scl_fall_w) begin
              if (mst_ack) begin
                cur_addr <= rd_next_w;
                shreg    <= rd_data_w;
                sda_oe_o <= ~rd_data_w[DATA_W-1];
                bit_cnt  <= '0;
                state    <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tw_mem_slave_chk.sv
module tw_mem_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic scl_fall,
  input logic busy,
  input logic wr_stb,
  input logic commit,
  input logic stop,
  input logic wc_block
);
  // R12
  oe_edge_only_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall));

  // R11
  silent_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> (!sda_oe && !wr_stb && !commit));

  // R9
  no_strobe_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !wc_block);

  // R8
  commit_follows_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop));

  // R6
  strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
endmodule

bind tw_mem_slave tw_mem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_fall(scl_fall_w),
  .busy(busy_i), .wr_stb(wr_stb_o), .commit(commit_o), .stop(stop_w),
  .wc_block(wc_block));

// File: tb/sim_tw_mem_slave.sv
`timescale 1ns/1ps
module sim_tw_mem_slave;
  localparam int AW = 7;
  localparam int DW = 8;
  localparam int Q  = 5;
  localparam int H  = 10;
  localparam int BUSY_CYC = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic wc = 1'b0, busy = 1'b0;
  logic sda_oe, wr_stb, commit;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic pgm_we = 1'b0;
  logic [AW-1:0] pgm_addr = '0;
  logic [DW-1:0] pgm_data = '0;
  logic sda_line;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  tw_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .wc_i(wc), .busy_i(busy), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .commit_o(commit), .pgm_we_i(pgm_we),
    .pgm_addr_i(pgm_addr), .pgm_data_i(pgm_data));

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] ref_mem [128];
  logic [DW-1:0] pbuf [128];
  bit            pval [128];
  int commit_cnt = 0, stb_cnt = 0;
  logic [AW-1:0] stb_log [16];
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pg_next(int a);
    return (a & ~3) | ((a + 1) & 3);
  endfunction

  // page-buffer and programming controller model
  always @(negedge clk) begin
    if (wr_stb) begin
      pbuf[wr_addr] = wr_data;
      pval[wr_addr] = 1;
      stb_log[stb_cnt % 16] = wr_addr;
      stb_cnt++;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) pval[i] = 0;
    forever begin
      @(negedge clk);
      if (commit) begin
        commit_cnt++;
        busy = 1'b1;
        repeat (BUSY_CYC) @(negedge clk);
        for (int i = 0; i < 128; i++) begin
          if (pval[i]) begin
            pgm_we = 1'b1; pgm_addr = AW'(i); pgm_data = pbuf[i];
            @(negedge clk);
            pval[i] = 0;
          end
        end
        pgm_we = 1'b0;
        busy = 1'b0;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    cyc(Q); sda_m = 1'b1; cyc(Q); scl_m = 1'b1; cyc(H); sda_m = 1'b0; cyc(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop;
    cyc(Q); sda_m = 1'b0; cyc(Q); scl_m = 1'b1; cyc(H); sda_m = 1'b1; cyc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      cyc(Q); sda_m = b[i]; cyc(Q); scl_m = 1'b1; cyc(H); scl_m = 1'b0;
    end
    cyc(Q); sda_m = 1'b1; cyc(Q); scl_m = 1'b1; cyc(H/2); acked = !sda_line;
    cyc(H/2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      cyc(Q); sda_m = 1'b1; cyc(Q); scl_m = 1'b1; cyc(H/2); b[i] = sda_line;
      cyc(H/2); scl_m = 1'b0;
    end
    cyc(Q); sda_m = !give_ack; cyc(Q); scl_m = 1'b1; cyc(H); scl_m = 1'b0;
  endtask

  task automatic wait_idle;
    cyc(4);
    while (busy) @(negedge clk);
    cyc(4);
  endtask

  // write: wc_mode 0 none, 1 only at START, 2 whole transfer, 3 only after address
  task automatic do_write(input int a, input int n, input logic [7:0] d [8], input int wc_mode);
    bit ack; int ad; int c0; bit blocked;
    c0 = commit_cnt;
    blocked = (wc_mode == 1) || (wc_mode == 2);
    wc = (wc_mode == 1 || wc_mode == 2);
    bus_start;
    if (wc_mode == 1) wc = 1'b0;
    send_byte({a[6:0], 1'b0}, ack);
    chk(ack, "R2 address ack (write)", ack, 1);
    if (wc_mode == 3) wc = 1'b1;
    ad = a;
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], ack);
      if (blocked) chk(!ack, "R9 data not acked when blocked", ack, 0);
      else if (wc_mode == 3) chk(ack, "R10 late wc ignored", ack, 1);
      else chk(ack, "R6 data ack", ack, 1);
      if (!blocked) ref_mem[ad] = d[k];
      ad = pg_next(ad);
    end
    bus_stop;
    wc = 1'b0;
    wait_idle;
    if (blocked)
      chk(commit_cnt == c0, "R9 no commit when blocked", commit_cnt - c0, 0);
    else
      chk(commit_cnt == c0 + (n > 0 ? 1 : 0), "R8 commit count after write",
          commit_cnt - c0, (n > 0 ? 1 : 0));
  endtask

  task automatic do_read(input int a, input int n, input string tag);
    bit ack; logic [7:0] b; int c0;
    c0 = commit_cnt;
    bus_start;
    send_byte({a[6:0], 1'b1}, ack);
    chk(ack, "R2 address ack (read)", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk(b == ref_mem[(a + k) % 128], tag, b, ref_mem[(a + k) % 128]);
    end
    cyc(Q);
    chk(!sda_oe, "R5 released after master NACK", sda_oe, 0);
    bus_stop;
    cyc(8);
    chk(commit_cnt == c0, "R8 no commit after read", commit_cnt - c0, 0);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [8];
    bit ack; int c0; int s0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) ref_mem[i] = 8'hFF;
    cyc(5); rst_n = 1'b1; cyc(5);
    // R1
    chk(!sda_oe && !wr_stb && !commit, "R1 reset outputs", {sda_oe, wr_stb, commit}, 0);
    do_read(7'h05, 1, "R1 erased byte reads FF");
    do_read(7'h7F, 1, "R1 erased top byte reads FF");

    // R6 R3 byte write and read
    d[0] = 8'hA5;
    do_write(7'h22, 1, d, 0);
    do_read(7'h22, 1, "R3 byte read");

    // R7 page wrap: six bytes from 0x11
    s0 = stb_cnt;
    for (int k = 0; k < 6; k++) d[k] = 8'(8'h30 + k);
    do_write(7'h11, 6, d, 0);
    chk(stb_log[(s0 + 3) % 16] == 7'h10, "R7 page wrap address", stb_log[(s0 + 3) % 16], 7'h10);
    chk(stb_log[(s0 + 4) % 16] == 7'h11, "R7 fifth byte reuses first", stb_log[(s0 + 4) % 16], 7'h11);
    do_read(7'h10, 4, "R7 page content");

    // R4 sequential read across 127 -> 0
    d[0] = 8'h11; d[1] = 8'h22;
    do_write(7'h7E, 2, d, 0);
    d[0] = 8'h33;
    do_write(7'h00, 1, d, 0);
    do_read(7'h7E, 4, "R4 sequential wrap");

    // R9 write-control only during START, and during whole transfer
    d[0] = 8'h5A; d[1] = 8'hC3;
    do_write(7'h40, 2, d, 1);
    do_read(7'h40, 2, "R9 memory unchanged (start-only wc)");
    do_write(7'h44, 1, d, 2);
    do_read(7'h44, 1, "R9 memory unchanged (wc high)");

    // R10 write-control after the address byte
    d[0] = 8'h77;
    do_write(7'h48, 1, d, 3);
    do_read(7'h48, 1, "R10 late wc write stored");

    // R8 address-only write: no commit
    do_write(7'h50, 0, d, 0);

    // R11 busy: transfer right after a committing STOP
    bus_start;
    send_byte({7'h60, 1'b0}, ack);
    send_byte(8'h99, ack);
    bus_stop;
    cyc(2);
    chk(busy, "R11 controller busy", busy, 1);
    c0 = commit_cnt; s0 = stb_cnt;
    bus_start;
    send_byte({7'h61, 1'b0}, ack);
    chk(!ack, "R11 address not acked when busy", ack, 0);
    send_byte(8'h12, ack);
    chk(!ack, "R11 data not acked when busy", ack, 0);
    bus_stop;
    chk(stb_cnt == s0, "R11 no strobe when busy", stb_cnt - s0, 0);
    ref_mem[7'h60] = 8'h99;
    wait_idle;
    chk(commit_cnt == c0, "R11 no commit from busy transfer", commit_cnt - c0, 0);
    do_read(7'h60, 2, "R11 ignored write left memory");

    // random mix
    for (int t = 0; t < 30; t++) begin
      int a; int n; int m;
      a = int'($urandom % 128);
      if ($urandom % 2 == 0) begin
        n = int'($urandom % 4) + 1;
        for (int k = 0; k < n; k++) d[k] = 8'($urandom);
        m = ($urandom % 4 == 0) ? 2 : 0;
        do_write(a, n, d, m);
      end else begin
        n = int'($urandom % 3) + 1;
        do_read(a, n, "R3 R4 random read");
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule